// File: doc/BRIEF.md
# Sparse Token Readout for a Hit-Latching Pixel Matrix

This block reads out a rectangular matrix of pixels in which only a few pixels fire between readouts. Each pixel keeps a hit flag and the Gray-coded time stamp that was on the shared time bus when it fired. When a readout is started, a single token walks the matrix in row-major order. Within a row, a priority search jumps straight to the next pixel that asks for service, and the pixels that have nothing to report cost no cycles. The granted pixel's column index and the row counter's value form the address at the edge of the array. Nothing about the address is stored in the pixel. The row counter advances only when the token runs off the last column of a row.

Each granted pixel yields a fixed 30-bit word: column address (10 bits), row address (10 bits), time stamp converted to binary (5 bits) and 5 flag bits. The word is sent most significant bit first on a one-bit valid/ready stream. A one-word staging register sits between the token and the shifter, so the token searches for the next hit while the current word is still being shifted out. Two controls serve testing. A force-all control makes every enabled pixel request the token. A per-pixel test-enable bit lets a broadcast test pulse fire selected pixels. A per-pixel disable bit keeps a noisy pixel from ever being granted.

Stream rules: a bit is transferred on a rising edge where `sdo_valid_o` and `sdo_ready_i` are both high. While `sdo_valid_o` is high and `sdo_ready_i` is low, `sdo_data_o` and `sdo_last_o` hold their values. `sdo_ready_i` may change in any cycle. When the consumer stalls, the staging register fills and the token waits on its current pixel. No data is dropped.

Top module: `sparse_token_readout`

## Requirements
- R1: After reset, `done_o` and `sdo_valid_o` are low, all hit flags are clear, and a readout started before any hit produces no word.
- R2: A hit pulse on a pixel sets its hit flag and captures `ts_gray_i` in the same clock edge. A further hit on a pixel whose flag is already set leaves the captured stamp unchanged.
- R3: Each word is 30 bits, sent MSB first, with `sdo_last_o` high on the 30th bit. Bits 29:20 hold the column index and bits 19:10 the row index, both zero-extended. Bits 9:5 hold the binary value of the captured Gray stamp (b[4]=g[4], b[i]=b[i+1]^g[i]). Bits 4:1 are zero. Bit 0 is 1 when the pixel's hit flag was set and 0 when it was read only because of force-all.
- R4: Within a readout, words appear in ascending row order and, within a row, in ascending column order. Pixels that are not requesting produce no word.
- R5: Granting a pixel clears its hit flag and zeroes its stored stamp, so a second readout with no new hits yields no word for it.
- R6: While `read_all_i` is high during a readout, every enabled pixel produces a word, including pixels with no hit. Those pixels report a stamp of 0 and flag bit 0.
- R7: A pixel whose disable bit is set is never granted, even under force-all. Its hit flag is kept and is read out once the bit is cleared.
- R8: Writing with `cfg_we_i` sets pixel `cfg_idx_i` (index = row*NCOL+col) to disable `cfg_dis_i` and test-enable `cfg_test_i`. A `test_pulse_i` cycle acts as a hit on every test-enabled pixel.
- R9: The serial stream obeys the valid/ready hold rule above, and every word arrives complete under random back-pressure.
- R10: `start_i` while idle begins a readout and drops `done_o` on the next edge. `done_o` rises once the token has passed the last pixel and the last bit has been accepted, and stays high until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit_i | input | NCOL*NROW (64) | Per-pixel hit pulses, bit row*NCOL+col |
| ts_gray_i | input | TSW (5) | Gray-coded time stamp broadcast to all pixels |
| test_pulse_i | input | 1 | Fires every test-enabled pixel |
| read_all_i | input | 1 | Forces every enabled pixel to request the token |
| cfg_we_i | input | 1 | Pixel configuration write strobe |
| cfg_idx_i | input | log2(NCOL*NROW) (6) | Pixel index for the configuration write |
| cfg_dis_i | input | 1 | Disable bit value to write |
| cfg_test_i | input | 1 | Test-enable bit value to write |
| start_i | input | 1 | Begins a readout when idle |
| done_o | output | 1 | Readout finished and output drained |
| sdo_valid_o | output | 1 | Serial bit valid |
| sdo_data_o | output | 1 | Serial bit, MSB of each word first |
| sdo_last_o | output | 1 | Marks the final bit of a word |
| sdo_ready_i | input | 1 | Consumer accepts the serial bit |

## Verification
The checker assumes that hit pulses, test pulses and configuration writes arrive only between readouts. A pixel could otherwise be set on the very edge on which it is granted, and the set would then win over the clear. The checker also assumes that `start_i` pulses only while the block is idle. The stimulus keeps to these rules: it injects hits, Gray stamps and configuration in idle phases, and only then pulses start. Within a readout, back-pressure is the one thing left free, so `sdo_ready_i` is randomised every cycle throughout the run.

// File: rtl/spr_pkg.sv
package spr_pkg;

  typedef enum logic {SC_IDLE = 1'b0, SC_RUN = 1'b1} scan_state_e;

  // Gray to binary for widths up to 31 bits; bits at or above w stay zero.
  function automatic logic [31:0] gray_to_bin(input logic [31:0] g, input int w);
    logic [31:0] b;
    b = '0;
    for (int i = 30; i >= 0; i--) begin
      if (i < w) b[i] = g[i] ^ b[i+1];
    end
    return b;
  endfunction

endpackage

// File: rtl/spr_pixel_array.sv
module spr_pixel_array #(
  parameter int NCOL = 8,
  parameter int NROW = 8,
  parameter int TSW  = 5,
  localparam int NPIX = NCOL * NROW,
  localparam int IW   = (NPIX > 1) ? $clog2(NPIX) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPIX-1:0]   hit_i,
  input  logic [TSW-1:0]    ts_gray_i,
  input  logic              test_pulse_i,
  input  logic              read_all_i,
  input  logic              cfg_we_i,
  input  logic [IW-1:0]     cfg_idx_i,
  input  logic              cfg_dis_i,
  input  logic              cfg_test_i,
  input  logic [NPIX-1:0]   clr_i,
  output logic [NPIX-1:0]   req_o,
  output logic [NPIX-1:0]   lat_o,
  output logic [NPIX-1:0]   dis_o,
  output logic [NPIX*TSW-1:0] ts_o
);

  for (genvar p = 0; p < NPIX; p++) begin : g_pix
    logic           lat_q, dis_q, ten_q, set_w;
    logic [TSW-1:0] ts_q;

    assign set_w = hit_i[p] | (test_pulse_i & ten_q);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lat_q <= 1'b0;
        ts_q  <= '0;
        dis_q <= 1'b0;
        ten_q <= 1'b0;
      end else begin
        if (cfg_we_i && (cfg_idx_i == IW'(p))) begin
          dis_q <= cfg_dis_i;
          ten_q <= cfg_test_i;
        end
        if (set_w && (!lat_q || clr_i[p])) begin
          lat_q <= 1'b1;
          ts_q  <= ts_gray_i;
        end else if (clr_i[p]) begin
          lat_q <= 1'b0;
          ts_q  <= '0;
        end
      end
    end

    assign req_o[p]             = (lat_q | read_all_i) & ~dis_q;
    assign lat_o[p]             = lat_q;
    assign dis_o[p]             = dis_q;
    assign ts_o[p*TSW +: TSW]   = ts_q;
  end

endmodule

// File: rtl/spr_token_scan.sv
module spr_token_scan
  import spr_pkg::*;
#(
  parameter int NCOL = 8,
  parameter int NROW = 8,
  localparam int NPIX = NCOL * NROW,
  localparam int XW   = (NCOL > 1) ? $clog2(NCOL) : 1,
  localparam int YW   = (NROW > 1) ? $clog2(NROW) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [NPIX-1:0] req_i,
  input  logic            stg_free_i,
  output logic            grant_o,
  output logic [XW-1:0]   gx_o,
  output logic [YW-1:0]   gy_o,
  output logic [NPIX-1:0] clr_o,
  output logic            finished_o
);

  scan_state_e    st_q;
  logic [YW-1:0]  row_q;
  logic [XW:0]    col_q;
  logic           fin_q;
  logic [NCOL-1:0] row_req;
  logic           cand_f;
  logic [XW-1:0]  cand_c;

  assign row_req = req_i[int'(row_q)*NCOL +: NCOL];

  // Skip logic: lowest requesting column at or after the token position.
  always_comb begin
    cand_f = 1'b0;
    cand_c = '0;
    for (int c = NCOL - 1; c >= 0; c--) begin
      if (row_req[c] && (c >= int'(col_q))) begin
        cand_f = 1'b1;
        cand_c = XW'(c);
      end
    end
  end

  assign grant_o = (st_q == SC_RUN) && cand_f && stg_free_i;
  assign gx_o    = cand_c;
  assign gy_o    = row_q;
  assign clr_o   = grant_o ? ({{(NPIX-1){1'b0}}, 1'b1} << (int'(row_q)*NCOL + int'(cand_c)))
                           : '0;
  assign finished_o = fin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SC_IDLE;
      row_q <= '0;
      col_q <= '0;
      fin_q <= 1'b0;
    end else begin
      case (st_q)
        SC_IDLE: begin
          if (start_i) begin
            st_q  <= SC_RUN;
            row_q <= '0;
            col_q <= '0;
            fin_q <= 1'b0;
          end
        end
        default: begin
          if (cand_f) begin
            if (stg_free_i) col_q <= (XW+1)'(cand_c) + 1'b1;
          end else if (row_q == YW'(NROW - 1)) begin
            st_q  <= SC_IDLE;
            fin_q <= 1'b1;
          end else begin
            row_q <= row_q + 1'b1;
            col_q <= '0;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/spr_word_serializer.sv
module spr_word_serializer #(
  parameter int WW = 30,
  localparam int CW = $clog2(WW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_valid_i,
  input  logic [WW-1:0] ld_word_i,
  output logic          ld_free_o,
  output logic          busy_o,
  output logic          sdo_valid_o,
  output logic          sdo_data_o,
  output logic          sdo_last_o,
  input  logic          sdo_ready_i
);

  logic          stg_v_q, sh_busy_q;
  logic [WW-1:0] stg_q, sh_q;
  logic [CW-1:0] cnt_q;
  logic          fire, last_bit, sh_empty_nx;

  assign fire        = sh_busy_q & sdo_ready_i;
  assign last_bit    = (cnt_q == CW'(1));
  assign sh_empty_nx = !sh_busy_q || (fire && last_bit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_v_q   <= 1'b0;
      stg_q     <= '0;
      sh_q      <= '0;
      sh_busy_q <= 1'b0;
      cnt_q     <= '0;
    end else begin
      if (sh_empty_nx && stg_v_q) begin
        sh_q      <= stg_q;
        cnt_q     <= CW'(WW);
        sh_busy_q <= 1'b1;
        stg_v_q   <= 1'b0;
      end else if (fire) begin
        sh_q      <= {sh_q[WW-2:0], 1'b0};
        cnt_q     <= cnt_q - 1'b1;
        sh_busy_q <= !last_bit;
      end
      if (ld_valid_i) begin
        stg_v_q <= 1'b1;
        stg_q   <= ld_word_i;
      end
    end
  end

  assign ld_free_o   = !stg_v_q;
  assign busy_o      = sh_busy_q | stg_v_q;
  assign sdo_valid_o = sh_busy_q;
  assign sdo_data_o  = sh_q[WW-1];
  assign sdo_last_o  = sh_busy_q & last_bit;

endmodule

// File: rtl/sparse_token_readout.sv
module sparse_token_readout
  import spr_pkg::*;
#(
  parameter int NCOL = 8,
  parameter int NROW = 8,
  parameter int AW   = 10,
  parameter int TSW  = 5,
  parameter int FLW  = 5,
  localparam int NPIX = NCOL * NROW,
  localparam int IW   = (NPIX > 1) ? $clog2(NPIX) : 1,
  localparam int XW   = (NCOL > 1) ? $clog2(NCOL) : 1,
  localparam int YW   = (NROW > 1) ? $clog2(NROW) : 1,
  localparam int WW   = 2 * AW + TSW + FLW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIX-1:0] hit_i,
  input  logic [TSW-1:0]  ts_gray_i,
  input  logic            test_pulse_i,
  input  logic            read_all_i,
  input  logic            cfg_we_i,
  input  logic [IW-1:0]   cfg_idx_i,
  input  logic            cfg_dis_i,
  input  logic            cfg_test_i,
  input  logic            start_i,
  output logic            done_o,
  output logic            sdo_valid_o,
  output logic            sdo_data_o,
  output logic            sdo_last_o,
  input  logic            sdo_ready_i
);

  logic [NPIX-1:0]     pix_req, pix_lat, pix_dis, pix_clr;
  logic [NPIX*TSW-1:0] pix_ts;
  logic                grant, stg_free, ser_busy, finished;
  logic [XW-1:0]       gx;
  logic [YW-1:0]       gy;
  logic [TSW-1:0]      ts_sel;
  logic                lat_sel;
  logic [WW-1:0]       word;
  int                  gidx;

  spr_pixel_array #(.NCOL(NCOL), .NROW(NROW), .TSW(TSW)) u_pix (
    .clk, .rst_n, .hit_i, .ts_gray_i, .test_pulse_i, .read_all_i,
    .cfg_we_i, .cfg_idx_i, .cfg_dis_i, .cfg_test_i,
    .clr_i(pix_clr), .req_o(pix_req), .lat_o(pix_lat), .dis_o(pix_dis), .ts_o(pix_ts)
  );

  spr_token_scan #(.NCOL(NCOL), .NROW(NROW)) u_scan (
    .clk, .rst_n, .start_i, .req_i(pix_req), .stg_free_i(stg_free),
    .grant_o(grant), .gx_o(gx), .gy_o(gy), .clr_o(pix_clr), .finished_o(finished)
  );

  // Peripheral multiplexer: address from the token position, stamp from the pixel.
  always_comb begin
    gidx    = int'(gy) * NCOL + int'(gx);
    ts_sel  = pix_ts[gidx*TSW +: TSW];
    lat_sel = pix_lat[gidx];
    word    = {AW'(gx), AW'(gy), TSW'(gray_to_bin(32'(ts_sel), TSW)),
               {(FLW-1){1'b0}}, lat_sel};
  end

  spr_word_serializer #(.WW(WW)) u_ser (
    .clk, .rst_n, .ld_valid_i(grant), .ld_word_i(word), .ld_free_o(stg_free),
    .busy_o(ser_busy), .sdo_valid_o, .sdo_data_o, .sdo_last_o, .sdo_ready_i
  );

  assign done_o = finished & ~ser_busy;

endmodule

// File: rtl/sparse_token_readout_chk.sv
module sparse_token_readout_chk #(
  parameter int NPIX = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            done_o,
  input logic            sdo_valid_o,
  input logic            sdo_data_o,
  input logic            sdo_last_o,
  input logic            sdo_ready_i,
  input logic [NPIX-1:0] pix_clr,
  input logic [NPIX-1:0] pix_req,
  input logic [NPIX-1:0] pix_dis
);

  p_hold_stream_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_valid_o && !sdo_ready_i) |=> (sdo_valid_o && $stable(sdo_data_o) && $stable(sdo_last_o)));

  p_single_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pix_clr));

  p_grant_needs_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_clr & ~pix_req) == '0);

  p_disabled_skipped_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_clr & pix_dis) == '0);

  p_done_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !sdo_valid_o);

  p_last_needs_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_last_o |-> sdo_valid_o);

endmodule

bind sparse_token_readout sparse_token_readout_chk #(.NPIX(NPIX)) u_chk (
  .clk, .rst_n, .done_o, .sdo_valid_o, .sdo_data_o, .sdo_last_o, .sdo_ready_i,
  .pix_clr, .pix_req, .pix_dis
);

// File: tb/sparse_token_readout_tb.sv
module sparse_token_readout_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCOL = 8;
  localparam int NROW = 8;
  localparam int NPIX = NCOL * NROW;
  localparam int TSW  = 5;
  localparam int WW   = 30;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NPIX-1:0] hit_i = '0;
  logic [TSW-1:0]  ts_gray_i = '0;
  logic            test_pulse_i = 1'b0, read_all_i = 1'b0, cfg_we_i = 1'b0;
  logic [5:0]      cfg_idx_i = '0;
  logic            cfg_dis_i = 1'b0, cfg_test_i = 1'b0, start_i = 1'b0;
  logic            done_o, sdo_valid_o, sdo_data_o, sdo_last_o;
  logic            sdo_ready_i = 1'b0;

  int checks = 0, fails = 0;
  logic            m_lat [NPIX];
  logic [TSW-1:0]  m_ts  [NPIX];
  logic            m_dis [NPIX];
  logic            m_ten [NPIX];
  logic [WW-1:0]   exp_w [NPIX];
  logic [WW-1:0]   got_w [NPIX];
  int              exp_n, got_n, bit_n;
  logic [WW-1:0]   cur_w;
  logic            pv, pr, pd, pl;

  always #(CLK_PERIOD/2) clk = ~clk;

  sparse_token_readout u_dut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  function automatic logic [TSW-1:0] g2b(input logic [TSW-1:0] g);
    logic [TSW-1:0] b;
    b[TSW-1] = g[TSW-1];
    for (int i = TSW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // Stream monitor: randomises ready, collects words, checks the hold rule (R9).
  always @(negedge clk) begin
    logic nr;
    if (!rst_n) begin
      pv = 1'b0; bit_n = 0; cur_w = '0;
    end else begin
      if (pv && !pr) begin
        checks++;
        if (!sdo_valid_o || sdo_data_o !== pd || sdo_last_o !== pl) begin
          fails++;
          $display("FAIL R9: hold broken actual v%0b d%0b expected d%0b", sdo_valid_o, sdo_data_o, pd);
        end
      end
      nr = ($urandom % 4) != 0;
      sdo_ready_i = nr;
      if (sdo_valid_o && nr) begin
        cur_w = {cur_w[WW-2:0], sdo_data_o};
        bit_n++;
        if (sdo_last_o) begin
          chk("R3 word length", 64'(bit_n), 64'(WW));
          if (got_n < NPIX) got_w[got_n] = cur_w;
          got_n++;
          bit_n = 0;
        end
      end
      pv = sdo_valid_o; pr = nr; pd = sdo_data_o; pl = sdo_last_o;
    end
  end

  task automatic hit_px(input int p, input logic [TSW-1:0] g);
    @(negedge clk);
    ts_gray_i = g; hit_i = '0; hit_i[p] = 1'b1;
    if (!m_lat[p]) begin m_lat[p] = 1'b1; m_ts[p] = g; end
    @(negedge clk);
    hit_i = '0;
  endtask

  task automatic cfg_px(input int p, input logic d, input logic t);
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_idx_i = 6'(p); cfg_dis_i = d; cfg_test_i = t;
    m_dis[p] = d; m_ten[p] = t;
    @(negedge clk);
    cfg_we_i = 1'b0;
  endtask

  task automatic test_inject(input logic [TSW-1:0] g);
    @(negedge clk);
    ts_gray_i = g; test_pulse_i = 1'b1;
    for (int p = 0; p < NPIX; p++)
      if (m_ten[p] && !m_lat[p]) begin m_lat[p] = 1'b1; m_ts[p] = g; end
    @(negedge clk);
    test_pulse_i = 1'b0;
  endtask

  task automatic do_scan(input string req);
    int tmo;
    exp_n = 0;
    for (int p = 0; p < NPIX; p++) begin
      if (!m_dis[p] && (m_lat[p] || read_all_i)) begin
        exp_w[exp_n] = {10'(p % NCOL), 10'(p / NCOL), g2b(m_ts[p]), 4'b0, m_lat[p]};
        exp_n++;
        m_lat[p] = 1'b0; m_ts[p] = '0;
      end
    end
    got_n = 0;
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk({req, " R10 done low after start"}, 64'(done_o), 64'd0);
    tmo = 0;
    while (!done_o && tmo < 20000) begin @(negedge clk); tmo++; end
    chk({req, " R10 done reached"}, 64'(done_o), 64'd1);
    chk({req, " R4 word count"}, 64'(got_n), 64'(exp_n));
    for (int i = 0; i < exp_n && i < got_n; i++)
      chk({req, " R3 R4 word"}, 64'(got_w[i]), 64'(exp_w[i]));
    repeat (3) @(negedge clk);
    chk({req, " R10 done holds"}, 64'(done_o), 64'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int p = 0; p < NPIX; p++) begin
      m_lat[p] = 1'b0; m_ts[p] = '0; m_dis[p] = 1'b0; m_ten[p] = 1'b0;
    end
    got_n = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 done after reset", 64'(done_o), 64'd0);
    chk("R1 valid after reset", 64'(sdo_valid_o), 64'd0);
    rst_n = 1'b1;
    do_scan("R1 empty scan");

    // R3: single hit, Gray stamp decoded
    hit_px(2*NCOL + 5, 5'b10110);
    do_scan("R3 single");

    // R4: sparse order across rows and the last pixel
    hit_px(7*NCOL + 7, 5'b00001);
    hit_px(0, 5'b11111);
    hit_px(3*NCOL + 1, 5'b01010);
    hit_px(3*NCOL + 0, 5'b00110);
    do_scan("R4 order");

    // R2: second hit keeps first stamp
    hit_px(4*NCOL + 4, 5'b00011);
    hit_px(4*NCOL + 4, 5'b11000);
    do_scan("R2 first stamp");

    // R5: rescan without hits yields nothing
    do_scan("R5 cleared");

    // R7: disabled pixel keeps its flag until re-enabled
    cfg_px(5*NCOL + 2, 1'b1, 1'b0);
    hit_px(5*NCOL + 2, 5'b01100);
    hit_px(6*NCOL + 3, 5'b00101);
    do_scan("R7 masked");
    cfg_px(5*NCOL + 2, 1'b0, 1'b0);
    do_scan("R7 re-enabled");

    // R6: force-all with one disabled pixel and one real hit
    cfg_px(1*NCOL + 6, 1'b1, 1'b0);
    hit_px(2*NCOL + 2, 5'b10001);
    @(negedge clk); read_all_i = 1'b1;
    do_scan("R6 read all");
    @(negedge clk); read_all_i = 1'b0;
    cfg_px(1*NCOL + 6, 1'b0, 1'b0);

    // R8: test injection on selected pixels
    cfg_px(9, 1'b0, 1'b1);
    cfg_px(44, 1'b0, 1'b1);
    cfg_px(63, 1'b0, 1'b1);
    test_inject(5'b01101);
    do_scan("R8 test pulse");
    cfg_px(9, 1'b0, 1'b0);
    cfg_px(44, 1'b0, 1'b0);
    cfg_px(63, 1'b0, 1'b0);

    // Random rounds (R2 R4 R9)
    for (int r = 0; r < 20; r++) begin
      int k;
      k = $urandom % 10;
      for (int j = 0; j < k; j++) hit_px($urandom % NPIX, 5'($urandom));
      do_scan("R4 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule